// File: doc/BRIEF.md
# Preemptive DMA Channel Scheduler

This block shares one master bus among a set of DMA channels (sixteen by default). Each channel owns a descriptor in a small local memory built from registers. A descriptor holds a source address, a destination address, signed per-beat offsets for each, a minor-loop byte count, a current iteration count and a preemption-enable bit. A one-cycle pulse on a channel's request line marks that channel pending. The scheduler then activates the highest-numbered pending channel by copying its descriptor into one of two working register slots. It moves the data as read-then-write beats over a plain request/acknowledge bus until the minor loop is spent. Finally it writes the advanced addresses and the decremented iteration count back to the descriptor memory and pulses a completion output.

Two slots let a long transfer give way. If the running channel has preemption enabled and a higher-numbered channel is pending, the scheduler checks at the end of a completed beat and loads the newcomer into the idle slot. The newcomer runs to the end of its minor loop. The interrupted channel then continues from the state held in its slot, without reading its descriptor again. Only one level of nesting exists: while both slots are occupied, any further request waits.

Top module: `dma_preempt_sched`

## Requirements
- R1: During and after reset, no bus request and no completion pulse is driven until a request arrives, and every descriptor in the local memory reads as zero.
- R2: Each beat reads the active source address, waits for the read acknowledge, and then writes the returned data to the active destination address. The write request rises only after a read acknowledge, and each request holds its address until it is acknowledged.
- R3: After every beat, the source address grows by the sign-extended 16-bit source offset and the destination address by the destination offset. A minor loop has ceil(nbytes / BEAT_BYTES) beats, with a minimum of one.
- R4: When a minor loop ends, the descriptor memory holds the advanced source and destination addresses and the iteration count minus one. `done_o` is high for exactly one cycle, the cycle after the final write acknowledge, and `done_ch_o` carries the channel index.
- R5: `done_major_o` is high with `done_o` exactly when the decremented iteration count is zero.
- R6: When no channel is active, the highest-numbered pending channel is activated first.
- R7: When the running channel's preemption bit is set and a higher-numbered channel is pending, the higher channel takes over only at a beat boundary. It then completes its whole minor loop with no other channel's beats in between.
- R8: A running channel whose preemption bit is clear finishes its minor loop before any other channel's beat.
- R9: A preempted channel resumes at its next beat. Every one of its beats is performed exactly once, in address order, and its final write-back is the same as if it had never been preempted.
- R10: While both slots are occupied, a further request waits until the preempting channel finishes. That request is then served before the preempted channel resumes if it is higher-numbered and the preempted channel allows preemption.
- R11: A single-cycle request pulse stays pending until its channel is activated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | NUM_CH | Per-channel service request pulses |
| cfg_we_i | input | 1 | Write one descriptor into local memory |
| cfg_ch_i | input | CH_W | Channel whose descriptor is written |
| cfg_saddr_i | input | 32 | Source address |
| cfg_daddr_i | input | 32 | Destination address |
| cfg_soff_i | input | 16 | Signed source offset per beat |
| cfg_doff_i | input | 16 | Signed destination offset per beat |
| cfg_nbytes_i | input | 16 | Minor-loop byte count |
| cfg_citer_i | input | 16 | Current iteration count |
| cfg_pe_i | input | 1 | Channel may be preempted |
| obs_ch_i | input | CH_W | Channel whose stored descriptor is observed |
| obs_saddr_o | output | 32 | Stored source address of obs_ch_i |
| obs_daddr_o | output | 32 | Stored destination address of obs_ch_i |
| obs_citer_o | output | 16 | Stored iteration count of obs_ch_i |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | 32 | Read address |
| rd_ack_i | input | 1 | Read acknowledge, data valid |
| rd_data_i | input | 32 | Read data |
| wr_req_o | output | 1 | Write request |
| wr_addr_o | output | 32 | Write address |
| wr_data_o | output | 32 | Write data |
| wr_ack_i | input | 1 | Write acknowledge |
| done_o | output | 1 | Minor loop finished (one cycle) |
| done_ch_o | output | CH_W | Channel that finished |
| done_major_o | output | 1 | Iteration count reached zero |

## Verification
A request pulse becomes pending at the next edge. The channel's first read request appears one cycle after that. Each beat is one decision cycle, then the read and the write, each held until its acknowledge. The completion pulse comes exactly one cycle after the final write acknowledge, and the bench checks this by comparing the cycle stamps it records for both events. The memory write-back lands on the edge that ends the pulse, so stored descriptors are read only after all expected completions have been seen. Ordering results are checked from the recorded sequence of write addresses, not at fixed cycles, so changes in acknowledge latency do not affect them.

// File: rtl/dma_sched_pkg.sv
// Shared widths, descriptor layout and engine state encoding for the
// preemptive DMA scheduler. Assumes byte addressing on the master bus.
package dma_sched_pkg;

    parameter int ADDR_W = 32;
    parameter int DATA_W = 32;
    parameter int OFF_W  = 16;
    parameter int CNT_W  = 16;

    // One channel's stored transfer descriptor.
    typedef struct packed {
        logic [ADDR_W-1:0] saddr;
        logic [ADDR_W-1:0] daddr;
        logic [OFF_W-1:0]  soff;     // signed, two's complement
        logic [OFF_W-1:0]  doff;     // signed, two's complement
        logic [CNT_W-1:0]  nbytes;   // minor-loop length in bytes
        logic [CNT_W-1:0]  citer;    // current iteration count
        logic              pe;       // channel may be preempted
    } desc_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_WBACK = 2'd3
    } eng_state_e;

endpackage

// File: rtl/dma_prio_pick.sv
// Fixed-priority picker: reports whether any channel is pending and the
// index of the highest-numbered pending one. Purely combinational.
module dma_prio_pick #(
    parameter int NUM_CH = 16,
    parameter int CH_W   = 4
) (
    input  logic [NUM_CH-1:0] pend_i,
    output logic              any_o,
    output logic [CH_W-1:0]   idx_o
);

    // Scan upward so the last (highest) set bit wins.
    always_comb begin
        any_o = |pend_i;
        idx_o = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (pend_i[i]) idx_o = CH_W'(i);
        end
    end

endmodule

// File: rtl/dma_desc_ram.sv
// Register-array descriptor memory. One full-descriptor write port for
// configuration, one partial write port for minor-loop write-back (which
// wins on a same-channel collision), one load read port and one observe
// read port, both asynchronous. Assumes the configuring agent does not
// rewrite a channel that is currently active.
module dma_desc_ram
    import dma_sched_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int CH_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we_i,
    input  logic [CH_W-1:0]   cfg_ch_i,
    input  desc_t             cfg_desc_i,
    input  logic              wb_we_i,
    input  logic [CH_W-1:0]   wb_ch_i,
    input  logic [ADDR_W-1:0] wb_saddr_i,
    input  logic [ADDR_W-1:0] wb_daddr_i,
    input  logic [CNT_W-1:0]  wb_citer_i,
    input  logic [CH_W-1:0]   ld_ch_i,
    output desc_t             ld_desc_o,
    input  logic [CH_W-1:0]   obs_ch_i,
    output logic [ADDR_W-1:0] obs_saddr_o,
    output logic [ADDR_W-1:0] obs_daddr_o,
    output logic [CNT_W-1:0]  obs_citer_o
);

    desc_t mem_q [NUM_CH];

    // Update every entry: clear on reset, write-back first, then config.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_CH; i++) begin
            if (!rst_n) begin
                mem_q[i] <= '0;
            end else if (wb_we_i && wb_ch_i == CH_W'(i)) begin
                mem_q[i].saddr <= wb_saddr_i;
                mem_q[i].daddr <= wb_daddr_i;
                mem_q[i].citer <= wb_citer_i;
            end else if (cfg_we_i && cfg_ch_i == CH_W'(i)) begin
                mem_q[i] <= cfg_desc_i;
            end
        end
    end

    // Asynchronous read ports.
    always_comb begin
        ld_desc_o   = mem_q[ld_ch_i];
        obs_saddr_o = mem_q[obs_ch_i].saddr;
        obs_daddr_o = mem_q[obs_ch_i].daddr;
        obs_citer_o = mem_q[obs_ch_i].citer;
    end

endmodule

// File: rtl/dma_addr_path.sv
// Two live descriptor slots and all address arithmetic. A slot is filled by
// load, advanced by step after each completed beat, and freed by release.
// Step and release act on the slot selected by act_i. Assumes the control
// never loads a slot that is occupied.
module dma_addr_path
    import dma_sched_pkg::*;
#(
    parameter int CH_W       = 4,
    parameter int BEAT_BYTES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 act_i,
    input  logic                 load_i,
    input  logic                 load_slot_i,
    input  logic [CH_W-1:0]      load_ch_i,
    input  desc_t                load_desc_i,
    input  logic                 step_i,
    input  logic                 release_i,
    output logic [1:0]           slot_vld_o,
    output logic [1:0][CH_W-1:0] slot_ch_o,
    output logic [1:0]           slot_pe_o,
    output logic [CH_W-1:0]      cur_ch_o,
    output logic [ADDR_W-1:0]    cur_saddr_o,
    output logic [ADDR_W-1:0]    cur_daddr_o,
    output logic [CNT_W-1:0]     cur_citer_o,
    output logic                 cur_last_o
);

    localparam int EXT_W = ADDR_W - OFF_W;
    localparam logic [CNT_W-1:0] BEAT_CNT = CNT_W'(BEAT_BYTES);

    logic [1:0]           vld_q;
    logic [1:0][CH_W-1:0] ch_q;
    logic [1:0]           pe_q;
    logic [ADDR_W-1:0]    saddr_q [2];
    logic [ADDR_W-1:0]    daddr_q [2];
    logic [OFF_W-1:0]     soff_q  [2];
    logic [OFF_W-1:0]     doff_q  [2];
    logic [CNT_W-1:0]     left_q  [2];
    logic [CNT_W-1:0]     citer_q [2];

    // Load, advance or free each of the two slots.
    always_ff @(posedge clk) begin
        for (int s = 0; s < 2; s++) begin
            if (!rst_n) begin
                vld_q[s]   <= 1'b0;
                ch_q[s]    <= '0;
                pe_q[s]    <= 1'b0;
                saddr_q[s] <= '0;
                daddr_q[s] <= '0;
                soff_q[s]  <= '0;
                doff_q[s]  <= '0;
                left_q[s]  <= '0;
                citer_q[s] <= '0;
            end else if (load_i && load_slot_i == 1'(s)) begin
                vld_q[s]   <= 1'b1;
                ch_q[s]    <= load_ch_i;
                pe_q[s]    <= load_desc_i.pe;
                saddr_q[s] <= load_desc_i.saddr;
                daddr_q[s] <= load_desc_i.daddr;
                soff_q[s]  <= load_desc_i.soff;
                doff_q[s]  <= load_desc_i.doff;
                left_q[s]  <= load_desc_i.nbytes;
                citer_q[s] <= load_desc_i.citer;
            end else if (act_i == 1'(s)) begin
                if (step_i) begin
                    saddr_q[s] <= saddr_q[s] + {{EXT_W{soff_q[s][OFF_W-1]}}, soff_q[s]};
                    daddr_q[s] <= daddr_q[s] + {{EXT_W{doff_q[s][OFF_W-1]}}, doff_q[s]};
                    left_q[s]  <= left_q[s] - BEAT_CNT;
                end
                if (release_i) vld_q[s] <= 1'b0;
            end
        end
    end

    // Present the active slot to the bus side.
    always_comb begin
        slot_vld_o  = vld_q;
        slot_ch_o   = ch_q;
        slot_pe_o   = pe_q;
        cur_ch_o    = ch_q[act_i];
        cur_saddr_o = saddr_q[act_i];
        cur_daddr_o = daddr_q[act_i];
        cur_citer_o = citer_q[act_i];
        cur_last_o  = left_q[act_i] <= BEAT_CNT;
    end

    AST_SLOT_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q == 2'b11) |-> (ch_q[0] != ch_q[1])); // R10
    AST_LOAD_INTO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !vld_q[load_slot_i]); // R10
    AST_PREEMPT_HIGHER: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && vld_q[~load_slot_i]) |-> (load_ch_i > ch_q[~load_slot_i])); // R7
    AST_PREEMPT_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && vld_q[~load_slot_i]) |-> pe_q[~load_slot_i]); // R8
    AST_STEP_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> vld_q[act_i]); // R3

endmodule

// File: rtl/dma_preempt_sched.sv
// Top of the preemptive DMA scheduler. Latches request pulses, picks the
// highest pending channel, loads it into a free slot, runs read-then-write
// beats, decides on preemption or resumption at each beat boundary and
// writes the descriptor back at minor-loop end. Assumes acknowledges only
// arrive while the matching request is high.
module dma_preempt_sched
    import dma_sched_pkg::*;
#(
    parameter  int NUM_CH     = 16,
    parameter  int BEAT_BYTES = 4,
    localparam int CH_W       = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] req_i,
    input  logic              cfg_we_i,
    input  logic [CH_W-1:0]   cfg_ch_i,
    input  logic [ADDR_W-1:0] cfg_saddr_i,
    input  logic [ADDR_W-1:0] cfg_daddr_i,
    input  logic [OFF_W-1:0]  cfg_soff_i,
    input  logic [OFF_W-1:0]  cfg_doff_i,
    input  logic [CNT_W-1:0]  cfg_nbytes_i,
    input  logic [CNT_W-1:0]  cfg_citer_i,
    input  logic              cfg_pe_i,
    input  logic [CH_W-1:0]   obs_ch_i,
    output logic [ADDR_W-1:0] obs_saddr_o,
    output logic [ADDR_W-1:0] obs_daddr_o,
    output logic [CNT_W-1:0]  obs_citer_o,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_ack_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              wr_req_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    input  logic              wr_ack_i,
    output logic              done_o,
    output logic [CH_W-1:0]   done_ch_o,
    output logic              done_major_o
);

    eng_state_e           state_q, state_d;
    logic                 act_q, act_d;
    logic [NUM_CH-1:0]    pend_q, pend_clr;
    logic [DATA_W-1:0]    dbuf_q;

    logic                 pick_any;
    logic [CH_W-1:0]      pick_idx;
    desc_t                ld_desc, cfg_desc;

    logic                 load_en, load_slot, step_en, rel_en, wb_en;
    logic [1:0]           slot_vld;
    logic [1:0][CH_W-1:0] slot_ch;
    logic [1:0]           slot_pe;
    logic [CH_W-1:0]      cur_ch;
    logic [ADDR_W-1:0]    cur_saddr, cur_daddr;
    logic [CNT_W-1:0]     cur_citer;
    logic                 cur_last;

    // Gather configuration inputs into one descriptor word.
    always_comb begin
        cfg_desc.saddr  = cfg_saddr_i;
        cfg_desc.daddr  = cfg_daddr_i;
        cfg_desc.soff   = cfg_soff_i;
        cfg_desc.doff   = cfg_doff_i;
        cfg_desc.nbytes = cfg_nbytes_i;
        cfg_desc.citer  = cfg_citer_i;
        cfg_desc.pe     = cfg_pe_i;
    end

    dma_prio_pick #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) u_pick (
        .pend_i (pend_q),
        .any_o  (pick_any),
        .idx_o  (pick_idx)
    );

    dma_desc_ram #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) u_ram (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we_i    (cfg_we_i),
        .cfg_ch_i    (cfg_ch_i),
        .cfg_desc_i  (cfg_desc),
        .wb_we_i     (wb_en),
        .wb_ch_i     (cur_ch),
        .wb_saddr_i  (cur_saddr),
        .wb_daddr_i  (cur_daddr),
        .wb_citer_i  (cur_citer - CNT_W'(1)),
        .ld_ch_i     (pick_idx),
        .ld_desc_o   (ld_desc),
        .obs_ch_i    (obs_ch_i),
        .obs_saddr_o (obs_saddr_o),
        .obs_daddr_o (obs_daddr_o),
        .obs_citer_o (obs_citer_o)
    );

    dma_addr_path #(
        .CH_W       (CH_W),
        .BEAT_BYTES (BEAT_BYTES)
    ) u_path (
        .clk         (clk),
        .rst_n       (rst_n),
        .act_i       (act_q),
        .load_i      (load_en),
        .load_slot_i (load_slot),
        .load_ch_i   (pick_idx),
        .load_desc_i (ld_desc),
        .step_i      (step_en),
        .release_i   (rel_en),
        .slot_vld_o  (slot_vld),
        .slot_ch_o   (slot_ch),
        .slot_pe_o   (slot_pe),
        .cur_ch_o    (cur_ch),
        .cur_saddr_o (cur_saddr),
        .cur_daddr_o (cur_daddr),
        .cur_citer_o (cur_citer),
        .cur_last_o  (cur_last)
    );

    // Sequence control: activation, preemption and resume decisions at
    // each beat boundary, then read, write and write-back.
    always_comb begin
        state_d   = state_q;
        act_d     = act_q;
        load_en   = 1'b0;
        load_slot = act_q;
        step_en   = 1'b0;
        rel_en    = 1'b0;
        wb_en     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (slot_vld[act_q]) begin
                    state_d = ST_READ;
                    if (pick_any && !slot_vld[~act_q] && slot_pe[act_q]
                            && pick_idx > slot_ch[act_q]) begin
                        load_en   = 1'b1;
                        load_slot = ~act_q;
                        act_d     = ~act_q;
                    end
                end else if (slot_vld[~act_q]) begin
                    state_d = ST_READ;
                    if (pick_any && slot_pe[~act_q] && pick_idx > slot_ch[~act_q]) begin
                        load_en   = 1'b1;
                        load_slot = act_q;
                    end else begin
                        act_d = ~act_q;
                    end
                end else if (pick_any) begin
                    state_d   = ST_READ;
                    load_en   = 1'b1;
                    load_slot = act_q;
                end
            end
            ST_READ: begin
                if (rd_ack_i) state_d = ST_WRITE;
            end
            ST_WRITE: begin
                if (wr_ack_i) begin
                    step_en = 1'b1;
                    state_d = cur_last ? ST_WBACK : ST_IDLE;
                end
            end
            ST_WBACK: begin
                wb_en   = 1'b1;
                rel_en  = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Register engine state and the active-slot pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            act_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            act_q   <= act_d;
        end
    end

    assign pend_clr = load_en ? (NUM_CH'(1) << pick_idx) : '0;

    // Hold request pulses until their channel is activated.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~pend_clr) | req_i;
    end

    // Capture read data for the following write.
    always_ff @(posedge clk) begin
        if (!rst_n)                           dbuf_q <= '0;
        else if (state_q == ST_READ && rd_ack_i) dbuf_q <= rd_data_i;
    end

    assign rd_req_o     = (state_q == ST_READ);
    assign rd_addr_o    = cur_saddr;
    assign wr_req_o     = (state_q == ST_WRITE);
    assign wr_addr_o    = cur_daddr;
    assign wr_data_o    = dbuf_q;
    assign done_o       = (state_q == ST_WBACK);
    assign done_ch_o    = cur_ch;
    assign done_major_o = (state_q == ST_WBACK) && (cur_citer == CNT_W'(1));

    AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_req_o) |-> $past(rd_ack_i)); // R2
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o))); // R2
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && !wr_ack_i) |=> (wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o))); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R4
    AST_DONE_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(wr_req_o && wr_ack_i)); // R4
    AST_MAJOR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_major_o |-> done_o); // R5

endmodule

// File: tb/dma_preempt_sched_tb_top.sv
module dma_preempt_sched_tb_top;
    import dma_sched_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH     = 16;
    localparam int CH_W       = 4;
    localparam int LAT        = 1;
    localparam int WDOG       = 100000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_CH-1:0] req_i = '0;
    logic              cfg_we_i = 1'b0;
    logic [CH_W-1:0]   cfg_ch_i = '0;
    logic [31:0]       cfg_saddr_i = '0, cfg_daddr_i = '0;
    logic [15:0]       cfg_soff_i = '0, cfg_doff_i = '0, cfg_nbytes_i = '0, cfg_citer_i = '0;
    logic              cfg_pe_i = 1'b0;
    logic [CH_W-1:0]   obs_ch_i = '0;
    logic [31:0]       obs_saddr_o, obs_daddr_o;
    logic [15:0]       obs_citer_o;
    logic              rd_req_o, wr_req_o;
    logic [31:0]       rd_addr_o, wr_addr_o, wr_data_o;
    logic              rd_ack_i = 1'b0, wr_ack_i = 1'b0;
    logic [31:0]       rd_data_i = '0;
    logic              done_o, done_major_o;
    logic [CH_W-1:0]   done_ch_o;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int rd_cnt = 0, wr_cnt = 0;
    logic [31:0] lg_addr [256];
    logic [31:0] lg_data [256];
    int          lg_cyc  [256];
    int          lg_n = 0;
    int          dn_ch  [16];
    int          dn_maj [16];
    int          dn_cyc [16];
    int          dn_n = 0;
    int          wcnt [NUM_CH];

    dma_preempt_sched #(.NUM_CH(NUM_CH), .BEAT_BYTES(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i),
        .cfg_we_i(cfg_we_i), .cfg_ch_i(cfg_ch_i), .cfg_saddr_i(cfg_saddr_i),
        .cfg_daddr_i(cfg_daddr_i), .cfg_soff_i(cfg_soff_i), .cfg_doff_i(cfg_doff_i),
        .cfg_nbytes_i(cfg_nbytes_i), .cfg_citer_i(cfg_citer_i), .cfg_pe_i(cfg_pe_i),
        .obs_ch_i(obs_ch_i), .obs_saddr_o(obs_saddr_o), .obs_daddr_o(obs_daddr_o),
        .obs_citer_o(obs_citer_o),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
        .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_ack_i(wr_ack_i),
        .done_o(done_o), .done_ch_o(done_ch_o), .done_major_o(done_major_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] dfun(logic [31:0] a);
        return {a[15:0], ~a[15:0]};
    endfunction

    function automatic int chan_of(int i);
        return int'(lg_addr[i][15:12]);
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h (t=%0t)", tag, got, exp, $time);
        end
    endtask

    // Bus responder and event logger, acting at falling edges.
    initial begin
        for (int i = 0; i < NUM_CH; i++) wcnt[i] = 0;
        forever begin
            @(negedge clk);
            if (done_o && dn_n < 16) begin
                dn_ch[dn_n] = int'(done_ch_o); dn_maj[dn_n] = int'(done_major_o);
                dn_cyc[dn_n] = cyc; dn_n++;
            end
            if (rd_ack_i) rd_ack_i = 1'b0;
            else if (rd_req_o) begin
                if (rd_cnt == LAT) begin
                    rd_ack_i = 1'b1; rd_data_i = dfun(rd_addr_o); rd_cnt = 0;
                end else rd_cnt++;
            end
            if (wr_ack_i) wr_ack_i = 1'b0;
            else if (wr_req_o) begin
                if (wr_cnt == LAT) begin
                    wr_ack_i = 1'b1; wr_cnt = 0;
                    if (lg_n < 256) begin
                        lg_addr[lg_n] = wr_addr_o; lg_data[lg_n] = wr_data_o;
                        lg_cyc[lg_n] = cyc; lg_n++;
                    end
                    wcnt[wr_addr_o[15:12]]++;
                end else wr_cnt++;
            end
        end
    end

    initial begin
        while (cyc < WDOG) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    task automatic clear_logs();
        lg_n = 0; dn_n = 0;
        for (int i = 0; i < NUM_CH; i++) wcnt[i] = 0;
    endtask

    task automatic set_desc(input int ch, input logic [31:0] sa, input logic [31:0] da,
                            input logic [15:0] so, input logic [15:0] doo,
                            input logic [15:0] nb, input logic [15:0] ci, input logic pe);
        @(negedge clk);
        cfg_ch_i = CH_W'(ch); cfg_saddr_i = sa; cfg_daddr_i = da; cfg_soff_i = so;
        cfg_doff_i = doo; cfg_nbytes_i = nb; cfg_citer_i = ci; cfg_pe_i = pe; cfg_we_i = 1'b1;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic pulse(input logic [NUM_CH-1:0] m);
        @(negedge clk); req_i = m;
        @(negedge clk); req_i = '0;
    endtask

    task automatic wait_dones(input int n);
        while (dn_n < n) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_write(input int ch);
        while (wcnt[ch] < 1) @(negedge clk);
    endtask

    task automatic scan(input int ch, output int first, output int last, output int cnt);
        first = -1; last = -1; cnt = 0;
        for (int i = 0; i < lg_n; i++) begin
            if (chan_of(i) == ch) begin
                if (first < 0) first = i;
                last = i; cnt++;
            end
        end
    endtask

    task automatic check_stream(input string tag, input int ch, input logic [31:0] sa,
                                input logic [31:0] da, input int n);
        int k = 0;
        for (int i = 0; i < lg_n; i++) begin
            if (chan_of(i) == ch) begin
                chk({tag, " addr"}, lg_addr[i], da + 32'(4 * k));
                chk({tag, " data"}, lg_data[i], dfun(sa + 32'(4 * k)));
                k++;
            end
        end
        chk({tag, " beats"}, 32'(k), 32'(n));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 rd_req in reset", 32'(rd_req_o), 0);
        chk("R1 wr_req in reset", 32'(wr_req_o), 0);
        chk("R1 done in reset", 32'(done_o), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 idle bus after reset", 32'(rd_req_o | wr_req_o | done_o), 0);
        obs_ch_i = 4'd7;
        @(negedge clk);
        chk("R1 descriptor cleared", obs_saddr_o | obs_daddr_o | 32'(obs_citer_o), 0);
    endtask

    task automatic t_single();
        clear_logs();
        set_desc(2, 32'h100, 32'h1000_2000, 16'd4, 16'd4, 16'd12, 16'd5, 1'b0);
        pulse(16'h0004);
        wait_dones(1);
        check_stream("R2 R3 ch2", 2, 32'h100, 32'h1000_2000, 3);
        chk("R4 done channel", 32'(dn_ch[0]), 2);
        chk("R4 done one cycle after last write", 32'(dn_cyc[0]), 32'(lg_cyc[2] + 1));
        chk("R5 no major", 32'(dn_maj[0]), 0);
        obs_ch_i = 4'd2; @(negedge clk);
        chk("R4 wb saddr", obs_saddr_o, 32'h10C);
        chk("R4 wb daddr", obs_daddr_o, 32'h1000_200C);
        chk("R4 wb citer", 32'(obs_citer_o), 4);
    endtask

    task automatic t_offsets();
        clear_logs();
        set_desc(3, 32'h200, 32'h1000_3100, 16'd0, 16'hFFF8, 16'd10, 16'd1, 1'b0);
        pulse(16'h0008);
        wait_dones(1);
        chk("R3 partial beats", 32'(lg_n), 3);
        for (int i = 0; i < 3; i++) begin
            chk("R3 negative dst step", lg_addr[i], 32'h1000_3100 - 32'(8 * i));
            chk("R3 zero src step", lg_data[i], dfun(32'h200));
        end
        chk("R5 major on last iteration", 32'(dn_maj[0]), 1);
        obs_ch_i = 4'd3; @(negedge clk);
        chk("R3 wb daddr", obs_daddr_o, 32'h1000_30E8);
        chk("R5 wb citer zero", 32'(obs_citer_o), 0);
    endtask

    task automatic t_prio();
        clear_logs();
        set_desc(1, 32'h300, 32'h1000_1000, 16'd4, 16'd4, 16'd8, 16'd3, 1'b0);
        set_desc(6, 32'h600, 32'h1000_6000, 16'd4, 16'd4, 16'd8, 16'd3, 1'b0);
        pulse(16'h0042);
        wait_dones(2);
        chk("R6 first beats belong to ch6", 32'(chan_of(0) == 6 && chan_of(1) == 6), 1);
        chk("R6 ch1 after ch6", 32'(chan_of(2)), 1);
        chk("R6 done order first", 32'(dn_ch[0]), 6);
        chk("R6 done order second", 32'(dn_ch[1]), 1);
    endtask

    task automatic t_preempt();
        int f9, l9, c9, f4, l4, c4;
        clear_logs();
        set_desc(4, 32'h400, 32'h1000_4000, 16'd4, 16'd4, 16'd32, 16'd2, 1'b1);
        set_desc(9, 32'h900, 32'h1000_9000, 16'd4, 16'd4, 16'd8, 16'd2, 1'b0);
        pulse(16'h0010);
        wait_write(4);
        pulse(16'h0200);
        wait_dones(2);
        scan(9, f9, l9, c9);
        scan(4, f4, l4, c4);
        chk("R7 ch9 inside ch4 loop", 32'(f9 > f4 && l4 > l9), 1);
        chk("R7 ch9 beats contiguous", 32'(l9 - f9), 1);
        check_stream("R9 ch4 resumed", 4, 32'h400, 32'h1000_4000, 8);
        chk("R9 preempting done first", 32'(dn_ch[0]), 9);
        chk("R9 preempted done last", 32'(dn_ch[1]), 4);
        obs_ch_i = 4'd4; @(negedge clk);
        chk("R9 wb saddr", obs_saddr_o, 32'h420);
        chk("R9 wb daddr", obs_daddr_o, 32'h1000_4020);
        chk("R9 wb citer", 32'(obs_citer_o), 1);
    endtask

    task automatic t_nopreempt();
        int f11, l11, c11;
        clear_logs();
        set_desc(5, 32'h500, 32'h1000_5000, 16'd4, 16'd4, 16'd32, 16'd2, 1'b0);
        set_desc(11, 32'hB00, 32'h1000_B000, 16'd4, 16'd4, 16'd8, 16'd2, 1'b0);
        pulse(16'h0020);
        wait_write(5);
        pulse(16'h0800);
        wait_dones(2);
        scan(11, f11, l11, c11);
        chk("R8 ch11 waits for whole ch5 loop", 32'(f11), 8);
        chk("R11 single pulse served", 32'(c11), 2);
        chk("R11 done for ch11", 32'(dn_ch[1]), 11);
    endtask

    task automatic t_nest();
        int f9, l9, c9, f12, l12, c12, f4, l4, c4;
        clear_logs();
        set_desc(4, 32'h400, 32'h1000_4000, 16'd4, 16'd4, 16'd32, 16'd2, 1'b1);
        set_desc(9, 32'h900, 32'h1000_9000, 16'd4, 16'd4, 16'd24, 16'd2, 1'b1);
        set_desc(12, 32'hC00, 32'h1000_C000, 16'd4, 16'd4, 16'd8, 16'd2, 1'b0);
        pulse(16'h0010);
        wait_write(4);
        pulse(16'h0200);
        wait_write(9);
        pulse(16'h1000);
        wait_dones(3);
        scan(9, f9, l9, c9);
        scan(12, f12, l12, c12);
        scan(4, f4, l4, c4);
        chk("R10 ch9 not preempted while slots full", 32'(l9 - f9), 5);
        chk("R10 ch12 after ch9", 32'(f12 > l9), 1);
        chk("R10 ch12 before ch4 resumes to end", 32'(l4 > l12), 1);
        chk("R10 ch4 beats", 32'(c4), 8);
        chk("R10 done order", 32'(dn_ch[0] == 9 && dn_ch[1] == 12 && dn_ch[2] == 4), 1);
    endtask

    initial begin
        t_reset();
        t_single();
        t_offsets();
        t_prio();
        t_preempt();
        t_nopreempt();
        t_nest();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule